// File: doc/BRIEF.md
# Lookup-Based Wide Population Counter

This block counts how many bits are set in a 150-bit word that arrives in parallel. A start strobe captures the word into a register. The captured word is cut into 12-bit slices. Each slice indexes a ones-count table that is filled when the design is elaborated. Every table has two read ports, so six tables serve the twelve full slices. The six bits left over after the last full slice are counted by a small adder and form a thirteenth partial count.

A serial accumulator then adds one partial count per fast clock cycle. After thirteen steps it presents the 8-bit total together with a one-cycle valid pulse. The fast clock runs well above the word rate, so one word is counted inside each word period. The word is held in its register for the whole accumulation, so the data input may change freely once the strobe has been taken. While a count is in progress the block takes no further strobe.

Top module: `popc_wide`

## Requirements
- R1: When `valid_o` is high, `count_o` equals the number of bits set to 1 in the word that was captured by the accepted start strobe.
- R2: Every 12-bit slice adds its own ones count, from 0 to 12, to the total. The six top bits [149:144] are also counted.
- R3: A start strobe with `start_i` high is accepted on a rising clock edge when the block is idle. `valid_o` is then high for exactly one cycle, in the 14th cycle after that edge: it rises on the 13th following edge.
- R4: A start strobe that arrives while a count is in progress is ignored. This includes the edge on which the result is produced. An ignored strobe produces no result and does not alter the result in progress.
- R5: Changes on `data_i` after the strobe has been accepted do not affect the result.
- R6: An all-zero word yields 0 and an all-ones word yields 150.
- R7: After reset, `valid_o` is 0 and `count_o` is 0. `count_o` holds its last result until the next result is produced.
- R8: A start strobe given in the same cycle as `valid_o` is accepted. This allows one word every 14 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast accumulation clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture `data_i` and begin counting |
| data_i | input | 150 | Word to be counted |
| count_o | output | 8 | Number of ones in the captured word |
| valid_o | output | 1 | One-cycle pulse marking a new `count_o` |

## Verification
Two things can happen in the same cycle: the result pulse for one word and the acceptance of the next strobe. A further collision is a strobe that lands on the final accumulation edge, one cycle earlier, which must be ignored. The bench drives words back to back so that each new strobe coincides with the previous valid pulse. It also pulses strobes, including one on the final busy edge, in the middle of a count. Each result is compared against a loop count held in a queue, and the bench checks the exact cycle of each pulse. Any extra pulse with no queued entry is reported as a failure.

// File: rtl/popc_pkg.sv
package popc_pkg;
    localparam int DEF_WORD_W  = 150;
    localparam int DEF_SLICE_W = 12;

    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/popc_table.sv
module popc_table #(
    parameter int AW = 12,
    parameter int DW = 4
) (
    input  logic [AW-1:0] addr_a,
    input  logic [AW-1:0] addr_b,
    output logic [DW-1:0] cnt_a,
    output logic [DW-1:0] cnt_b
);
    localparam int DEPTH = 1 << AW;

    function automatic logic [DEPTH*DW-1:0] build_tab();
        logic [DEPTH*DW-1:0] t;
        t = '0;
        for (int i = 0; i < DEPTH; i++) begin
            t[i*DW +: DW] = DW'($countones(i));
        end
        return t;
    endfunction

    localparam logic [DEPTH*DW-1:0] TAB = build_tab();

    always_comb begin
        cnt_a = TAB[int'(addr_a)*DW +: DW];
        cnt_b = TAB[int'(addr_b)*DW +: DW];
    end
endmodule

// File: rtl/popc_partials.sv
module popc_partials #(
    parameter int W     = 150,
    parameter int SL    = 12,
    parameter int PW    = 4,
    parameter int NPART = 13
) (
    input  logic [W-1:0]            word_i,
    output logic [NPART-1:0][PW-1:0] parts_o
);
    localparam int NSLICE = W / SL;
    localparam int NTAB   = NSLICE / 2;
    localparam int REM    = W - NSLICE * SL;

    for (genvar t = 0; t < NTAB; t++) begin : g_tab
        popc_table #(.AW(SL), .DW(PW)) u_tab (
            .addr_a (word_i[(2*t)*SL   +: SL]),
            .addr_b (word_i[(2*t+1)*SL +: SL]),
            .cnt_a  (parts_o[2*t]),
            .cnt_b  (parts_o[2*t+1])
        );
    end

    if (REM > 0) begin : g_rem
        logic [PW-1:0] rem_d;
        always_comb begin
            rem_d = '0;
            for (int i = 0; i < REM; i++) begin
                rem_d = rem_d + PW'(word_i[NSLICE*SL + i]);
            end
        end
        assign parts_o[NSLICE] = rem_d;
    end
endmodule

// File: rtl/popc_accum.sv
module popc_accum #(
    parameter int W     = 150,
    parameter int PW    = 4,
    parameter int NPART = 13,
    parameter int CW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [W-1:0]             data_i,
    input  logic [NPART-1:0][PW-1:0] parts_i,
    output logic [W-1:0]             word_o,
    output logic [CW-1:0]            count_o,
    output logic                     valid_o
);
    localparam int IW = (NPART > 1) ? $clog2(NPART) : 1;
    localparam logic [IW-1:0] LAST = IW'(NPART - 1);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] idx;
        logic [CW-1:0] acc;
        logic [CW-1:0] cnt;
        logic          vld;
        logic [W-1:0]  word;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [CW-1:0] sum_d;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        sum_d    = st_q.acc + CW'(parts_i[st_q.idx]);
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.acc  = '0;
                st_d.word = data_i;
            end
        end else begin
            st_d.acc = sum_d;
            st_d.idx = st_q.idx + 1'b1;
            if (st_q.idx == LAST) begin
                st_d.busy = 1'b0;
                st_d.vld  = 1'b1;
                st_d.cnt  = sum_d;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o  = st_q.word;
    assign count_o = st_q.cnt;
    assign valid_o = st_q.vld;

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(count_o) <= W)); // R1
    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> $stable(word_o)); // R5
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start_i && st_q.idx != LAST) |=> st_q.busy); // R4
    AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(count_o)); // R7
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && start_i) |=> (st_q.busy && st_q.idx == '0)); // R8
endmodule

// File: rtl/popc_wide.sv
module popc_wide #(
    parameter int W  = popc_pkg::DEF_WORD_W,
    parameter int SL = popc_pkg::DEF_SLICE_W,
    parameter int CW = popc_pkg::cnt_width(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [W-1:0]  data_i,
    output logic [CW-1:0] count_o,
    output logic          valid_o
);
    localparam int NSLICE = W / SL;
    localparam int REM    = W - NSLICE * SL;
    localparam int NPART  = NSLICE + ((REM > 0) ? 1 : 0);
    localparam int PW     = popc_pkg::cnt_width(SL);

    logic [W-1:0]             word_q;
    logic [NPART-1:0][PW-1:0] parts;

    popc_partials #(.W(W), .SL(SL), .PW(PW), .NPART(NPART)) u_parts (
        .word_i  (word_q),
        .parts_o (parts)
    );

    popc_accum #(.W(W), .PW(PW), .NPART(NPART), .CW(CW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .data_i  (data_i),
        .parts_i (parts),
        .word_o  (word_q),
        .count_o (count_o),
        .valid_o (valid_o)
    );
endmodule

// File: tb/tb_popc_wide.sv
module tb_popc_wide;
    localparam int CLK_PERIOD = 10;
    localparam int W = 150;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [W-1:0] data_i = '0;
    logic [7:0]   count_o;
    logic         valid_o;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_cnt = 0;
    bit done = 0;

    int    exp_q[$];
    int    cyc_q[$];
    string req_q[$];

    popc_wide dut (.clk(clk), .rst_n(rst_n), .start_i(start_i),
                   .data_i(data_i), .count_o(count_o), .valid_o(valid_o));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_count(input logic [W-1:0] w);
        int s = 0;
        for (int i = 0; i < W; i++) s += int'(w[i]);
        return s;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // driver: one strobe, then wait so the next call lands on the valid cycle (R8)
    task automatic apply(input logic [W-1:0] w, input string req);
        @(negedge clk);
        data_i  = w;
        start_i = 1'b1;
        exp_q.push_back(ref_count(w));
        cyc_q.push_back(cyc + 14);
        req_q.push_back(req);
        @(negedge clk);
        start_i = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    // driver with interference while busy: R4 and R5
    task automatic apply_noisy(input logic [W-1:0] w, input logic [W-1:0] junk);
        @(negedge clk);
        data_i  = w;
        start_i = 1'b1;
        exp_q.push_back(ref_count(w));
        cyc_q.push_back(cyc + 14);
        req_q.push_back("R4/R5");
        for (int k = 1; k <= 13; k++) begin
            @(negedge clk);
            data_i  = junk ^ W'(k);
            start_i = (k % 3 == 0) || (k == 13);
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                check("R4 unexpected result", 1, 0);
            end else begin
                check({req_q[0], " R1 count"}, int'(count_o), exp_q[0]);
                check("R3 latency", cyc, cyc_q[0]);
                last_cnt = int'(count_o);
                void'(exp_q.pop_front());
                void'(cyc_q.pop_front());
                void'(req_q.pop_front());
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        check("watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [W-1:0] w;
        repeat (3) @(negedge clk);
        check("R7 reset valid", int'(valid_o), 0);
        check("R7 reset count", int'(count_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        apply('0, "R6 zero");
        apply('1, "R6 ones");
        for (int s = 0; s < 12; s++) apply(W'(12'hFFF) << (12*s), "R2 slice");
        apply(W'(6'h3F) << 144, "R2 top bits");
        for (int b = 0; b < W; b++) apply(W'(1) << b, "R2 single bit");
        for (int r = 0; r < 40; r++) begin
            w = {$urandom, $urandom, $urandom, $urandom, $urandom};
            apply(w, "R1 random");
        end
        for (int r = 0; r < 8; r++) begin
            w = {$urandom, $urandom, $urandom, $urandom, $urandom};
            apply_noisy(w, ~w);
        end
        apply_noisy('0, '1);
        apply('1, "R8 back-to-back");

        repeat (3) @(negedge clk);
        check("R7 hold count", int'(count_o), last_cnt);
        check("R7 valid low", int'(valid_o), 0);
        repeat (5) @(negedge clk);
        check("R7 hold count later", int'(count_o), last_cnt);
        check("R4 no pending results", exp_q.size(), 0);
        finish_run();
    end
endmodule